// File: doc/BRIEF.md
# Acquisition sequencer

The acquisition sequencer decides which input a shared measurement converter samples and when it samples it. A mode register picks a measurement set of one, two or five inputs, drawn from a primary pair, an auxiliary pair and an internal temperature input. The same register chooses whether the set repeats without end or runs once for each write. For single runs it also chooses whether the converter stays idle or is powered down once the run completes. A global operation register can power the whole device down. A status register reports when a single run has finished and whether any conversion in that run overflowed.

Software uses a byte-wide register port made of an address, a write strobe, a read strobe, write data and combinational read data. A write strobe to the restore address carries no data and returns every register to its default. Toward the converter the block sends a one-cycle start pulse with a channel code. It then waits for a one-cycle done pulse that carries an overflow flag, so only one request is outstanding at any time.

Top module: `acq_sequencer`

## Requirements
- R1: After reset the operation register (address 0x01) reads 0x80, the mode register (address 0xD2) reads 0x0A and the status register (address 0xD3) reads 0x00. Operation bits 6:0, mode bit 7 and status bits 7:2 always read as 0.
- R2: A write strobe to address 0x12 is the restore command, and its data byte is ignored. A read from any address other than 0x01, 0xD2 or 0xD3 returns 0. Writes to the status register have no effect.
- R3: Channel codes on `cnv_chan` are 0 primary shunt, 1 primary bus, 2 auxiliary shunt, 3 auxiliary bus and 4 temperature. Mode bits 2:0 select the set: 0→{0}, 1→{1}, 2→{0,1}, 3→{2}, 4→{3}, 5→{2,3}, 6→{4}, 7→{0,1,2,3,4}, issued in that order.
- R4: With mode bit 3 = 1 (continuous), the selected set is issued over and over, always starting from its first channel, until the settings change.
- R5: A mode write with bit 3 = 0, bit 5 = 0 and bit 6 = 0 (trigger) runs the selected set exactly once. Every such write starts a new run.
- R6: Mode bit 4 chooses the state after a triggered run completes. With 0 the block is idle and `cnv_pd` stays low. With 1, `cnv_pd` goes high and stays high until the next mode write or restore.
- R7: While mode bit 6 = 1, `cnv_pd` is high and no start is issued. While mode bit 5 = 1, no start is issued and `cnv_pd` is not raised by that bit.
- R8: With operation bit 7 = 0, `chip_pd` and `cnv_pd` are high and no new start is issued. Writing bit 7 = 1 resumes sequencing.
- R9: When a triggered run completes, status bit 1 (ready) is set and status bit 0 becomes the OR of the overflow flags of every conversion in that run. Continuous operation leaves the status untouched.
- R10: The status register clears when it is read (the read returns the value held before clearing) and on any mode write with bit 3 = 0.
- R11: No start pulse is issued while a previous request has not yet received its done pulse.
- R12: A mode write, operation write or restore that arrives during a run lets the in-flight conversion finish. The block then issues nothing more from the old set and applies the new settings. An interrupted triggered run does not set the status.
- R13: The restore command returns the operation and mode registers to their defaults, clears the status and ends a post-trigger power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, used to clear the status on read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| cnv_start | output | 1 | One-cycle conversion request |
| cnv_chan | output | 3 | Channel code, valid with `cnv_start` |
| cnv_done | input | 1 | One-cycle conversion completion |
| cnv_ovf | input | 1 | Overflow flag, valid with `cnv_done` |
| cnv_pd | output | 1 | Converter power-down |
| chip_pd | output | 1 | Whole-device power-down |

## Verification
The bound checker watches on every cycle that only one request is outstanding, that channel codes stay in range and that no start is issued while the converter is powered down. It also confirms that a completed run and a post-trigger power-down each follow a done pulse. Only the bench scenarios can show the channel order of each of the eight sets and the single-run behaviour with both post-trigger choices. The same holds for the accumulated overflow, the status clear rules, the interrupted run and the effects of restore and device power-down.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

   localparam int CHAN_W  = 3;
   localparam int SET_MAX = 5;
   localparam int IDX_W   = $clog2(SET_MAX + 1);

   localparam logic [6:0] MODE_DEFAULT = 7'h0A;

   typedef enum logic [CHAN_W-1:0] {
      CH_PRI_SHUNT = 3'd0,
      CH_PRI_BUS   = 3'd1,
      CH_AUX_SHUNT = 3'd2,
      CH_AUX_BUS   = 3'd3,
      CH_TEMP      = 3'd4
   } chan_e;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_WAIT = 1'b1
   } seq_state_e;

   // bit order matches the register layout, bit 6 down to bit 0
   typedef struct packed {
      logic       cnv_off;
      logic       hold_idle;
      logic       park_pd;
      logic       cont;
      logic [2:0] set_code;
   } mode_t;

   function automatic logic [IDX_W-1:0] set_len(input logic [2:0] code);
      case (code)
         3'd2, 3'd5: set_len = IDX_W'(2);
         3'd7:       set_len = IDX_W'(SET_MAX);
         default:    set_len = IDX_W'(1);
      endcase
   endfunction

   function automatic logic [CHAN_W-1:0] set_chan(input logic [2:0] code,
                                                  input logic [IDX_W-1:0] idx);
      case (code)
         3'd0:    set_chan = CH_PRI_SHUNT;
         3'd1:    set_chan = CH_PRI_BUS;
         3'd2:    set_chan = CHAN_W'(idx);
         3'd3:    set_chan = CH_AUX_SHUNT;
         3'd4:    set_chan = CH_AUX_BUS;
         3'd5:    set_chan = CHAN_W'(CH_AUX_SHUNT) + CHAN_W'(idx);
         3'd6:    set_chan = CH_TEMP;
         default: set_chan = CHAN_W'(idx);
      endcase
   endfunction

endpackage

// File: rtl/acq_seq_regs.sv
module acq_seq_regs
   import acq_seq_pkg::*;
#(
   parameter int               ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] OP_ADDR    = ADDR_W'('h01),
   parameter logic [ADDR_W-1:0] MODE_ADDR  = ADDR_W'('hD2),
   parameter logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'('hD3),
   parameter logic [ADDR_W-1:0] RST_ADDR   = ADDR_W'('h12),
   parameter bit               READ_CLEARS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              op_on,
   output mode_t             mode,
   output logic              mode_wr,
   output logic              op_wr,
   output logic              restore,
   output logic              trig_wr,
   input  logic              set_done,
   input  logic              set_ovf
);

   logic  op_q, rdy_q, ovf_q;
   mode_t mode_q;
   logic  stat_rd, trig_clr, rd_clr;

   assign mode_wr  = reg_wr && (reg_addr == MODE_ADDR);
   assign op_wr    = reg_wr && (reg_addr == OP_ADDR);
   assign restore  = reg_wr && (reg_addr == RST_ADDR);
   assign stat_rd  = reg_rd && (reg_addr == STAT_ADDR);
   assign trig_clr = mode_wr && !reg_wdata[3];
   assign trig_wr  = trig_clr && !reg_wdata[6] && !reg_wdata[5];

   generate
      if (READ_CLEARS) begin : g_rd_clr
         assign rd_clr = stat_rd;
      end else begin : g_rd_keep
         assign rd_clr = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= 1'b1;
         mode_q <= mode_t'(MODE_DEFAULT);
         rdy_q  <= 1'b0;
         ovf_q  <= 1'b0;
      end else if (restore) begin
         op_q   <= 1'b1;
         mode_q <= mode_t'(MODE_DEFAULT);
         rdy_q  <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         if (op_wr)   op_q   <= reg_wdata[7];
         if (mode_wr) mode_q <= mode_t'(reg_wdata[6:0]);
         if (set_done) begin
            rdy_q <= 1'b1;
            ovf_q <= set_ovf;
         end else if (rd_clr || trig_clr) begin
            rdy_q <= 1'b0;
            ovf_q <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = 8'h00;
      if (reg_addr == OP_ADDR)        reg_rdata = {op_q, 7'b0};
      else if (reg_addr == MODE_ADDR) reg_rdata = {1'b0, mode_q};
      else if (reg_addr == STAT_ADDR) reg_rdata = {6'b0, rdy_q, ovf_q};
   end

   assign op_on = op_q;
   assign mode  = mode_q;

endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
   import acq_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_on,
   input  mode_t             mode,
   input  logic              mode_wr,
   input  logic              cfg_wr,
   input  logic              trig_wr,
   input  logic              restore,
   output logic              cnv_start,
   output logic [CHAN_W-1:0] cnv_chan,
   input  logic              cnv_done,
   input  logic              cnv_ovf,
   output logic              park_pd,
   output logic              set_done,
   output logic              set_ovf
);

   seq_state_e       state;
   logic [IDX_W-1:0] idx, idx_nxt;
   logic [2:0]       seq_code;
   logic             seq_trig, seq_post, abort_q, acc_ovf, trig_pend;
   logic             run_en, go, last, ovf_n;

   assign run_en  = op_on && !mode.cnv_off && !mode.hold_idle;
   assign go      = (state == SQ_IDLE) && run_en && !cfg_wr && (mode.cont || trig_pend);
   assign idx_nxt = idx + 1'b1;
   assign last    = (idx_nxt == set_len(seq_code));
   assign ovf_n   = acc_ovf || cnv_ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         idx       <= '0;
         seq_code  <= '0;
         seq_trig  <= 1'b0;
         seq_post  <= 1'b0;
         abort_q   <= 1'b0;
         acc_ovf   <= 1'b0;
         trig_pend <= 1'b0;
         park_pd   <= 1'b0;
         cnv_start <= 1'b0;
         cnv_chan  <= '0;
         set_done  <= 1'b0;
         set_ovf   <= 1'b0;
      end else begin
         cnv_start <= 1'b0;
         set_done  <= 1'b0;
         if (mode_wr || restore) park_pd <= 1'b0;

         if (trig_wr)
            trig_pend <= 1'b1;
         else if (mode_wr || restore || go || (state == SQ_IDLE && !run_en))
            trig_pend <= 1'b0;

         case (state)
            SQ_IDLE: begin
               if (go) begin
                  cnv_start <= 1'b1;
                  cnv_chan  <= set_chan(mode.set_code, '0);
                  idx       <= '0;
                  seq_code  <= mode.set_code;
                  seq_trig  <= !mode.cont;
                  seq_post  <= mode.park_pd;
                  acc_ovf   <= 1'b0;
                  abort_q   <= 1'b0;
                  state     <= SQ_WAIT;
               end
            end
            SQ_WAIT: begin
               if (cfg_wr) abort_q <= 1'b1;
               if (cnv_done) begin
                  acc_ovf <= ovf_n;
                  if (abort_q || cfg_wr) begin
                     state <= SQ_IDLE;
                  end else if (last) begin
                     state <= SQ_IDLE;
                     if (seq_trig) begin
                        set_done <= 1'b1;
                        set_ovf  <= ovf_n;
                        if (seq_post) park_pd <= 1'b1;
                     end
                  end else begin
                     idx       <= idx_nxt;
                     cnv_start <= 1'b1;
                     cnv_chan  <= set_chan(seq_code, idx_nxt);
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
   import acq_seq_pkg::*;
#(
   parameter int               ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] OP_ADDR    = ADDR_W'('h01),
   parameter logic [ADDR_W-1:0] MODE_ADDR  = ADDR_W'('hD2),
   parameter logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'('hD3),
   parameter logic [ADDR_W-1:0] RST_ADDR   = ADDR_W'('h12),
   parameter bit               READ_CLEARS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              cnv_start,
   output logic [2:0]        cnv_chan,
   input  logic              cnv_done,
   input  logic              cnv_ovf,
   output logic              cnv_pd,
   output logic              chip_pd
);

   if (ADDR_W < 1) begin : g_bad_width
      $error("acq_sequencer: ADDR_W must be at least 1");
   end
   if (OP_ADDR == MODE_ADDR || OP_ADDR == STAT_ADDR || OP_ADDR == RST_ADDR ||
       MODE_ADDR == STAT_ADDR || MODE_ADDR == RST_ADDR || STAT_ADDR == RST_ADDR) begin : g_bad_map
      $error("acq_sequencer: register addresses must be distinct");
   end

   logic  op_on, mode_wr, op_wr, restore, trig_wr, cfg_wr;
   logic  set_done, set_ovf, park_pd;
   mode_t mode;

   assign cfg_wr = mode_wr || op_wr || restore;

   acq_seq_regs #(
      .ADDR_W(ADDR_W), .OP_ADDR(OP_ADDR), .MODE_ADDR(MODE_ADDR),
      .STAT_ADDR(STAT_ADDR), .RST_ADDR(RST_ADDR), .READ_CLEARS(READ_CLEARS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .op_on(op_on), .mode(mode), .mode_wr(mode_wr), .op_wr(op_wr),
      .restore(restore), .trig_wr(trig_wr), .set_done(set_done), .set_ovf(set_ovf)
   );

   acq_seq_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .op_on(op_on), .mode(mode), .mode_wr(mode_wr),
      .cfg_wr(cfg_wr), .trig_wr(trig_wr), .restore(restore),
      .cnv_start(cnv_start), .cnv_chan(cnv_chan), .cnv_done(cnv_done),
      .cnv_ovf(cnv_ovf), .park_pd(park_pd), .set_done(set_done), .set_ovf(set_ovf)
   );

   assign chip_pd = !op_on;
   assign cnv_pd  = mode.cnv_off || park_pd || !op_on;

endmodule

// File: rtl/acq_seq_checker.sv
module acq_seq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cnv_start,
   input logic [2:0] cnv_chan,
   input logic       cnv_done,
   input logic       cnv_pd,
   input logic       set_done,
   input logic       park_pd
);

   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_q <= 1'b0;
      else if (cnv_start) busy_q <= 1'b1;
      else if (cnv_done)  busy_q <= 1'b0;
   end

   a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> !busy_q);

   a_r3_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> (cnv_chan <= 3'd4));

   a_r7_no_start_when_pd: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> !cnv_pd);

   a_r9_done_follows_conversion: assert property (@(posedge clk) disable iff (!rst_n)
      set_done |-> $past(cnv_done));

   a_r6_park_after_conversion: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(park_pd) |-> $past(cnv_done));

endmodule

bind acq_sequencer acq_seq_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
   .cnv_done(cnv_done), .cnv_pd(cnv_pd), .set_done(set_done), .park_pd(park_pd)
);

// File: tb/acq_sequencer_test.sv
module acq_sequencer_test;

   localparam int LAT = 3;
   localparam int LOG = 4096;
   localparam logic [7:0] A_OP = 8'h01, A_MODE = 8'hD2, A_STAT = 8'hD3, A_RST = 8'h12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic cnv_start, cnv_done = 1'b0, cnv_ovf = 1'b0, cnv_pd, chip_pd;
   logic [2:0] cnv_chan;

   always #5 clk = ~clk;

   acq_sequencer uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnv_start(cnv_start),
      .cnv_chan(cnv_chan), .cnv_done(cnv_done), .cnv_ovf(cnv_ovf),
      .cnv_pd(cnv_pd), .chip_pd(chip_pd)
   );

   int checks = 0, fails = 0;
   int log_n = 0, base = 0, lat_cnt = 0;
   logic [2:0] log_ch [LOG];
   logic [2:0] cur = '0;
   logic pend = 1'b0;
   logic [4:0] ovf_mask = '0;

   // converter model: fixed latency, one done pulse per start
   always @(negedge clk) begin
      cnv_done <= 1'b0;
      cnv_ovf  <= 1'b0;
      if (rst_n) begin
         if (pend) begin
            if (lat_cnt == 1) begin
               cnv_done <= 1'b1;
               cnv_ovf  <= ovf_mask[cur];
               pend     <= 1'b0;
            end else lat_cnt <= lat_cnt - 1;
         end
         if (cnv_start) begin
            log_ch[log_n % LOG] <= cnv_chan;
            log_n   <= log_n + 1;
            cur     <= cnv_chan;
            pend    <= 1'b1;
            lat_cnt <= LAT;
         end
      end
   end

   function automatic int e_len(int c);
      if (c == 2 || c == 5) return 2;
      if (c == 7) return 5;
      return 1;
   endfunction

   function automatic int e_ch(int c, int i);
      case (c)
         0: return 0;
         1: return 1;
         2: return i;
         3: return 2;
         4: return 3;
         5: return 2 + i;
         6: return 4;
         default: return i;
      endcase
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_ge(input string req, input string what, input int act, input int lim);
      checks++;
      if (act < lim) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected>=%0d", req, what, act, lim);
      end
   endtask

   task automatic quiet();
      wr(A_MODE, 8'h20);
      tick(12);
      base = log_n;
   endtask

   task automatic wait_starts(int n);
      int t = 0;
      while ((log_n - base) < n && t < 200) begin
         tick(1);
         t++;
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d;
      int n;
      tick(3);
      rst_n = 1'b1;

      // R1 reset values
      rd(A_OP, d);   chk("R1", "op reset", d, 8'h80);
      rd(A_MODE, d); chk("R1", "mode reset", d, 8'h0A);
      rd(A_STAT, d); chk("R1", "status reset", d, 8'h00);
      chk("R1", "chip_pd reset", chip_pd, 0);
      chk("R1", "cnv_pd reset", cnv_pd, 0);

      // R2 decode, ignored writes
      rd(8'h55, d); chk("R2", "unmapped read", d, 0);
      quiet();
      wr(A_STAT, 8'hFF); rd(A_STAT, d); chk("R2", "status write ignored", d, 0);
      wr(A_OP, 8'hFF);   rd(A_OP, d);   chk("R1", "op low bits", d, 8'h80);
      wr(A_MODE, 8'hA0); rd(A_MODE, d); chk("R1", "mode bit7", d, 8'h20);

      // R3 R5 R6 R9 R10 triggered sweep over all set codes and post states
      for (int c = 0; c < 8; c++) begin
         for (int p = 0; p < 2; p++) begin
            logic eo;
            quiet();
            ovf_mask = 5'((c * 7 + p * 11 + 3) & 31);
            eo = 1'b0;
            for (int i = 0; i < e_len(c); i++) eo |= ovf_mask[e_ch(c, i)];
            wr(A_MODE, {3'b000, p[0], 1'b0, c[2:0]});
            tick(40);
            chk("R5", $sformatf("trigger count code %0d", c), log_n - base, e_len(c));
            for (int i = 0; i < e_len(c); i++)
               chk("R3", $sformatf("code %0d step %0d", c, i), log_ch[(base + i) % LOG], e_ch(c, i));
            chk("R6", $sformatf("post state %0d", p), cnv_pd, p);
            rd(A_STAT, d); chk("R9", "status after trigger", d, {6'b0, 1'b1, eo});
            rd(A_STAT, d); chk("R10", "status cleared by read", d, 0);
         end
      end

      // R5 each trigger write starts a new run
      quiet();
      wr(A_MODE, 8'h06); tick(20);
      wr(A_MODE, 8'h06); tick(20);
      chk("R5", "two triggers", log_n - base, 2);

      // R10 trigger write clears status
      rd(A_STAT, d);
      wr(A_MODE, 8'h01); tick(20);
      wr(A_MODE, 8'h21);
      rd(A_STAT, d); chk("R10", "status cleared by trigger write", d, 0);

      // R4 R9 continuous
      foreach (ovf_mask[k]) ovf_mask[k] = 1'b1;
      for (int s = 0; s < 4; s++) begin
         int c;
         c = (s == 0) ? 0 : (s == 1) ? 2 : (s == 2) ? 5 : 7;
         quiet();
         wr(A_MODE, 8'h08 | 8'(c));
         tick(80);
         rd(A_STAT, d); chk("R9", "continuous leaves status", d, 0);
         wr(A_MODE, 8'h20);
         tick(12);
         n = log_n - base;
         chk_ge("R4", $sformatf("continuous count code %0d", c), n, 2 * e_len(c));
         for (int i = 0; i < n; i++)
            chk("R4", $sformatf("continuous code %0d entry %0d", c, i),
                log_ch[(base + i) % LOG], e_ch(c, i % e_len(c)));
      end

      // R7 idle and converter power-down bits
      quiet();
      wr(A_MODE, 8'h28); tick(40);
      chk("R7", "idle bit starts", log_n - base, 0);
      chk("R7", "idle bit cnv_pd", cnv_pd, 0);
      wr(A_MODE, 8'h22); tick(40);
      chk("R7", "trigger with idle bit", log_n - base, 0);
      wr(A_MODE, 8'h48); tick(40);
      chk("R7", "pd bit starts", log_n - base, 0);
      chk("R7", "pd bit cnv_pd", cnv_pd, 1);

      // R8 device power-down
      wr(A_MODE, 8'h0F); tick(20);
      wr(A_OP, 8'h00); tick(15);
      base = log_n; tick(40);
      chk("R8", "no starts when off", log_n - base, 0);
      chk("R8", "chip_pd", chip_pd, 1);
      chk("R8", "cnv_pd when off", cnv_pd, 1);
      rd(A_OP, d); chk("R8", "op reads off", d, 0);
      wr(A_OP, 8'h80); tick(40);
      chk_ge("R8", "resume starts", log_n - base, 1);
      chk("R8", "chip_pd cleared", chip_pd, 0);

      // R12 interrupted run replaced by a new trigger
      quiet();
      ovf_mask = 5'b10000;
      wr(A_MODE, 8'h07);
      wait_starts(2);
      wr(A_MODE, 8'h06);
      tick(40);
      chk("R12", "abort count", log_n - base, 3);
      chk("R12", "abort entry0", log_ch[base % LOG], 0);
      chk("R12", "abort entry1", log_ch[(base + 1) % LOG], 1);
      chk("R12", "new set entry", log_ch[(base + 2) % LOG], 4);
      rd(A_STAT, d); chk("R12", "status of new run", d, 8'h03);

      // R12 interrupted run with no replacement sets no status
      quiet();
      wr(A_MODE, 8'h07);
      wait_starts(2);
      wr(A_MODE, 8'h28);
      tick(30);
      chk("R12", "stop count", log_n - base, 2);
      rd(A_STAT, d); chk("R12", "no status after abort", d, 0);

      // R13 restore
      quiet();
      wr(A_MODE, 8'h13); tick(30);
      chk("R6", "parked before restore", cnv_pd, 1);
      rd(A_STAT, d);
      wr(A_RST, 8'hFF);
      rd(A_MODE, d); chk("R13", "mode default", d, 8'h0A);
      rd(A_OP, d);   chk("R13", "op default", d, 8'h80);
      chk("R13", "park cleared", cnv_pd, 0);
      base = log_n; tick(40);
      n = log_n - base;
      chk_ge("R13", "default continuous resumes", n, 4);
      for (int i = 1; i < n; i++)
         chk("R13", "alternating pair", log_ch[(base + i) % LOG], 1 - log_ch[(base + i - 1) % LOG]);

      summary();
      $finish;
   end

endmodule